// File: doc/BRIEF.md
# Single-Entry Address-Space-Tagged Translation Cache

This block caches one Sv39 translation for a memory management unit. It keeps one slot: a 16-bit address-space identifier, a global flag, the 39-bit virtual address and 56-bit physical address of the mapping, the 64-bit leaf page table entry, the physical address at which that leaf entry lives, and a page mask derived from the level at which the leaf was found (4 KiB, 2 MiB or 1 GiB page).

A lookup presents an identifier and a virtual address. One cycle later the block returns a registered response: hit or miss, the translated physical address, the stored leaf entry and its location. A page walker loads the slot with a fill. After a hit, the surrounding logic can overwrite the stored leaf entry, for example after setting its accessed or dirty bits. A flush can carry an identifier filter, an address filter, both or neither. It removes the slot only when the slot passes every filter that is present.

Top module: `sv39_single_tlb`

## Requirements
- R1: After synchronous reset the slot is empty: every lookup misses, and all response outputs read zero until the first lookup response.
- R2: A lookup hits only when the slot is valid, the virtual bits above the stored page mask equal those of the lookup address, and the slot is global or its identifier equals the lookup identifier.
- R3: The page mask follows `fill_level`: 0 keeps the 12 low bits as offset, 1 keeps 21 bits and 2 keeps 30 bits. Only the virtual bits above the mask take part in the compare.
- R4: On a hit `rsp_paddr` is the filled physical address with its mask bits cleared, ORed with the lookup address's mask bits. `rsp_pte` and `rsp_pte_addr` return the stored values and `rsp_idx` is 0.
- R5: `rsp_valid` rises in the cycle after `lk_valid`. The response reflects the slot as it stood before that cycle's fill, update or flush. On a miss `rsp_paddr`, `rsp_pte` and `rsp_pte_addr` are zero.
- R6: A fill replaces the slot unconditionally, whatever it held, and takes priority over a flush or update in the same cycle.
- R7: An update overwrites only the stored leaf entry of a valid slot. On an empty slot it has no effect. When a flush clears the slot in the same cycle, the flush wins.
- R8: A flush with neither filter clears the slot, including a global one.
- R9: A flush filtered by identifier only clears a non-global slot whose identifier is equal. A global slot and a slot with another identifier are kept.
- R10: A flush filtered by address only clears the slot when the address bits above the slot's page mask match, whatever the identifier or global flag.
- R11: A flush with both filters clears the slot only when both the identifier rule of R9 and the address rule of R10 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 16 | Lookup address-space identifier |
| lk_vaddr | input | 39 | Lookup virtual address |
| fill_en | input | 1 | Load the slot |
| fill_asid | input | 16 | Identifier for the fill |
| fill_global | input | 1 | Fill marks mapping global |
| fill_level | input | 2 | Leaf level: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| fill_vaddr | input | 39 | Virtual address of the fill |
| fill_paddr | input | 56 | Physical address of the fill |
| fill_pte | input | 64 | Leaf page table entry |
| fill_pte_addr | input | 56 | Physical location of the leaf entry |
| upd_en | input | 1 | Overwrite the stored leaf entry |
| upd_pte | input | 64 | New leaf entry value |
| flush_en | input | 1 | Flush request |
| flush_use_asid | input | 1 | Apply the identifier filter |
| flush_asid | input | 16 | Identifier filter value |
| flush_use_addr | input | 1 | Apply the address filter |
| flush_vaddr | input | 39 | Address filter value |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_idx | output | 1 | Index of the hit slot (always 0) |
| rsp_paddr | output | 56 | Translated physical address |
| rsp_pte | output | 64 | Stored leaf entry |
| rsp_pte_addr | output | 56 | Stored leaf entry location |

## Verification
A corrupted slot shows up on the first lookup response after it, one cycle after the request. A lost valid bit turns an expected hit into a miss, and a stale valid bit turns a flushed mapping into a false hit. A wrong stored mask moves the hit boundary, so addresses one page away hit or miss wrongly and the offset bits of `rsp_paddr` come out wrong. Each fill, update and flush case is therefore followed by lookups on both sides of the page boundary and with foreign identifiers, and the scoreboard compares the full response of every lookup.

// File: rtl/tlb1_pkg.sv
package tlb1_pkg;
  localparam int ASID_W_D   = 16;
  localparam int VA_W_D     = 39;
  localparam int PA_W_D     = 56;
  localparam int PTE_W_D    = 64;
  localparam int OFS_W_D    = 12;
  localparam int LVL_BITS_D = 9;
  localparam int LEVELS_D   = 3;

  typedef enum logic [1:0] {
    LVL_4K = 2'd0,
    LVL_2M = 2'd1,
    LVL_1G = 2'd2
  } page_level_e;
endpackage

// File: rtl/tlb1_page_mask.sv
module tlb1_page_mask #(
  parameter int VA_W     = 39,
  parameter int OFS_W    = 12,
  parameter int LVL_BITS = 9,
  parameter int LEVELS   = 3,
  parameter int LVL_W    = 2
) (
  input  logic [LVL_W-1:0] level,
  output logic [VA_W-1:0]  mask
);
  logic [VA_W-1:0] masks [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign masks[l] = ~({VA_W{1'b1}} << (OFS_W + LVL_BITS * l));
  end

  // Levels beyond the table fall back to the smallest page.
  always_comb begin
    mask = masks[0];
    for (int l = 0; l < LEVELS; l++) begin
      if (level == LVL_W'(l)) mask = masks[l];
    end
  end
endmodule

// File: rtl/tlb1_page_cmp.sv
module tlb1_page_cmp #(
  parameter int VA_W = 39
) (
  input  logic [VA_W-1:0] a,
  input  logic [VA_W-1:0] b,
  input  logic [VA_W-1:0] mask,
  output logic            eq
);
  assign eq = ((a ^ b) & ~mask) == '0;
endmodule

// File: rtl/tlb1_entry_store.sv
module tlb1_entry_store #(
  parameter int ASID_W = 16,
  parameter int VA_W   = 39,
  parameter int PA_W   = 56,
  parameter int PTE_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic [VA_W-1:0]   fill_vaddr,
  input  logic [PA_W-1:0]   fill_paddr,
  input  logic [PTE_W-1:0]  fill_pte,
  input  logic [PA_W-1:0]   fill_pte_addr,
  input  logic [VA_W-1:0]   fill_mask,
  input  logic              upd_en,
  input  logic [PTE_W-1:0]  upd_pte,
  input  logic              clr,
  output logic              e_valid,
  output logic [ASID_W-1:0] e_asid,
  output logic              e_global,
  output logic [VA_W-1:0]   e_vaddr,
  output logic [PA_W-1:0]   e_paddr,
  output logic [PTE_W-1:0]  e_pte,
  output logic [PA_W-1:0]   e_pte_addr,
  output logic [VA_W-1:0]   e_mask
);
  localparam int PAD_W = PA_W - VA_W;

  logic [PA_W-1:0] fill_mask_pa;
  assign fill_mask_pa = {{PAD_W{1'b0}}, fill_mask};

  // Valid bit: fill beats clear.
  always_ff @(posedge clk) begin
    if (rst)          e_valid <= 1'b0;
    else if (fill_en) e_valid <= 1'b1;
    else if (clr)     e_valid <= 1'b0;
  end

  // Payload carries no reset; it is qualified by e_valid.
  always_ff @(posedge clk) begin
    if (fill_en) begin
      e_asid     <= fill_asid;
      e_global   <= fill_global;
      e_vaddr    <= fill_vaddr;
      e_paddr    <= fill_paddr & ~fill_mask_pa;
      e_pte      <= fill_pte;
      e_pte_addr <= fill_pte_addr;
      e_mask     <= fill_mask;
    end else if (upd_en && e_valid && !clr) begin
      e_pte      <= upd_pte;
    end
  end
endmodule

// File: rtl/sv39_single_tlb.sv
module sv39_single_tlb
  import tlb1_pkg::*;
#(
  parameter int ASID_W   = ASID_W_D,
  parameter int VA_W     = VA_W_D,
  parameter int PA_W     = PA_W_D,
  parameter int PTE_W    = PTE_W_D,
  parameter int OFS_W    = OFS_W_D,
  parameter int LVL_BITS = LVL_BITS_D,
  parameter int LEVELS   = LEVELS_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              fill_en,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic [1:0]        fill_level,
  input  logic [VA_W-1:0]   fill_vaddr,
  input  logic [PA_W-1:0]   fill_paddr,
  input  logic [PTE_W-1:0]  fill_pte,
  input  logic [PA_W-1:0]   fill_pte_addr,
  input  logic              upd_en,
  input  logic [PTE_W-1:0]  upd_pte,
  input  logic              flush_en,
  input  logic              flush_use_asid,
  input  logic [ASID_W-1:0] flush_asid,
  input  logic              flush_use_addr,
  input  logic [VA_W-1:0]   flush_vaddr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [0:0]        rsp_idx,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [PTE_W-1:0]  rsp_pte,
  output logic [PA_W-1:0]   rsp_pte_addr
);
  localparam int LVL_W = 2;
  localparam int PAD_W = PA_W - VA_W;

  logic              e_valid, e_global;
  logic [ASID_W-1:0] e_asid;
  logic [VA_W-1:0]   e_vaddr, e_mask, fill_mask;
  logic [PA_W-1:0]   e_paddr, e_pte_addr;
  logic [PTE_W-1:0]  e_pte;
  logic              lk_page_eq, fl_page_eq;
  logic              lk_hit, fl_asid_ok, fl_addr_ok, fl_clr;

  tlb1_page_mask #(
    .VA_W(VA_W), .OFS_W(OFS_W), .LVL_BITS(LVL_BITS),
    .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_mask (
    .level (fill_level),
    .mask  (fill_mask)
  );

  tlb1_page_cmp #(.VA_W(VA_W)) u_lk_cmp (
    .a(e_vaddr), .b(lk_vaddr), .mask(e_mask), .eq(lk_page_eq)
  );

  tlb1_page_cmp #(.VA_W(VA_W)) u_fl_cmp (
    .a(e_vaddr), .b(flush_vaddr), .mask(e_mask), .eq(fl_page_eq)
  );

  assign lk_hit     = e_valid && lk_page_eq && (e_global || e_asid == lk_asid);
  assign fl_asid_ok = !flush_use_asid || (!e_global && e_asid == flush_asid);
  assign fl_addr_ok = !flush_use_addr || fl_page_eq;
  assign fl_clr     = flush_en && e_valid && fl_asid_ok && fl_addr_ok;

  tlb1_entry_store #(
    .ASID_W(ASID_W), .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W)
  ) u_store (
    .clk           (clk),
    .rst           (rst),
    .fill_en       (fill_en),
    .fill_asid     (fill_asid),
    .fill_global   (fill_global),
    .fill_vaddr    (fill_vaddr),
    .fill_paddr    (fill_paddr),
    .fill_pte      (fill_pte),
    .fill_pte_addr (fill_pte_addr),
    .fill_mask     (fill_mask),
    .upd_en        (upd_en),
    .upd_pte       (upd_pte),
    .clr           (fl_clr),
    .e_valid       (e_valid),
    .e_asid        (e_asid),
    .e_global      (e_global),
    .e_vaddr       (e_vaddr),
    .e_paddr       (e_paddr),
    .e_pte         (e_pte),
    .e_pte_addr    (e_pte_addr),
    .e_mask        (e_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_idx      <= '0;
      rsp_paddr    <= '0;
      rsp_pte      <= '0;
      rsp_pte_addr <= '0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= lk_valid && lk_hit;
      rsp_idx      <= '0;
      if (lk_valid && lk_hit) begin
        rsp_paddr    <= e_paddr | {{PAD_W{1'b0}}, lk_vaddr & e_mask};
        rsp_pte      <= e_pte;
        rsp_pte_addr <= e_pte_addr;
      end else begin
        rsp_paddr    <= '0;
        rsp_pte      <= '0;
        rsp_pte_addr <= '0;
      end
    end
  end
endmodule

// File: rtl/tlb1_checker.sv
module tlb1_checker #(
  parameter int ASID_W = 16,
  parameter int VA_W   = 39
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [ASID_W-1:0] lk_asid,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic              fill_en,
  input logic [ASID_W-1:0] fill_asid,
  input logic [VA_W-1:0]   fill_vaddr,
  input logic              flush_en,
  input logic              flush_use_asid,
  input logic              flush_use_addr,
  input logic              rsp_valid,
  input logic              rsp_hit
);
  // R5: response follows the request by one cycle
  p_rsp_latency_r5: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R5: no hit without a response
  p_hit_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  // R1: first lookup after reset misses
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && lk_valid) |=> !rsp_hit);

  // R8: unfiltered flush leaves nothing to hit
  p_flush_all_r8: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !$past(rst) && !$past(fill_en) &&
     $past(flush_en && !flush_use_asid && !flush_use_addr)) |=> !rsp_hit);

  // R6: a fill is visible to the next lookup of the same page and identifier
  p_fill_then_hit_r6: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !$past(rst) && $past(fill_en) &&
     lk_vaddr == $past(fill_vaddr) && lk_asid == $past(fill_asid)) |=> rsp_hit);
endmodule

bind sv39_single_tlb tlb1_checker #(.ASID_W(ASID_W), .VA_W(VA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .lk_valid       (lk_valid),
  .lk_asid        (lk_asid),
  .lk_vaddr       (lk_vaddr),
  .fill_en        (fill_en),
  .fill_asid      (fill_asid),
  .fill_vaddr     (fill_vaddr),
  .flush_en       (flush_en),
  .flush_use_asid (flush_use_asid),
  .flush_use_addr (flush_use_addr),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit)
);

// File: tb/sv39_single_tlb_tb.sv
module sv39_single_tlb_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0;
  logic [15:0] lk_asid = 0;
  logic [38:0] lk_vaddr = 0;
  logic        fill_en = 0;
  logic [15:0] fill_asid = 0;
  logic        fill_global = 0;
  logic [1:0]  fill_level = 0;
  logic [38:0] fill_vaddr = 0;
  logic [55:0] fill_paddr = 0;
  logic [63:0] fill_pte = 0;
  logic [55:0] fill_pte_addr = 0;
  logic        upd_en = 0;
  logic [63:0] upd_pte = 0;
  logic        flush_en = 0;
  logic        flush_use_asid = 0;
  logic [15:0] flush_asid = 0;
  logic        flush_use_addr = 0;
  logic [38:0] flush_vaddr = 0;
  logic        rsp_valid, rsp_hit;
  logic [0:0]  rsp_idx;
  logic [55:0] rsp_paddr, rsp_pte_addr;
  logic [63:0] rsp_pte;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct packed {
    logic        hit;
    logic [55:0] pa;
    logic [63:0] pte;
    logic [55:0] pta;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  sv39_single_tlb u_dut (.*);

  function automatic logic [55:0] xlate(input logic [55:0] pa, input logic [38:0] va,
                                        input int lvl);
    logic [55:0] m;
    m = (56'd1 << (12 + 9 * lvl)) - 56'd1;
    return (pa & ~m) | ({17'd0, va} & m);
  endfunction

  // Monitor: pop and compare each response.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R5 unexpected response: actual valid=1 expected none");
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (rsp_hit !== e.hit || rsp_paddr !== e.pa || rsp_pte !== e.pte ||
            rsp_pte_addr !== e.pta || rsp_idx !== 1'b0) begin
          n_fail++;
          $display("FAIL %s: actual hit=%0b pa=%h pte=%h pta=%h idx=%0d expected hit=%0b pa=%h pte=%h pta=%h idx=0",
                   t, rsp_hit, rsp_paddr, rsp_pte, rsp_pte_addr, rsp_idx,
                   e.hit, e.pa, e.pte, e.pta);
        end
      end
    end
  end

  task automatic expect_rsp(input logic hit, input logic [55:0] pa, input logic [63:0] pte,
                            input logic [55:0] pta, input string tag);
    exp_t e;
    e.hit = hit; e.pa = hit ? pa : '0; e.pte = hit ? pte : '0; e.pta = hit ? pta : '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic lookup(input logic [15:0] asid, input logic [38:0] va, input logic hit,
                        input logic [55:0] pa, input logic [63:0] pte, input logic [55:0] pta,
                        input string tag);
    lk_valid = 1; lk_asid = asid; lk_vaddr = va;
    expect_rsp(hit, pa, pte, pta, tag);
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic fill(input logic [15:0] asid, input logic g, input int lvl,
                      input logic [38:0] va, input logic [55:0] pa,
                      input logic [63:0] pte, input logic [55:0] pta);
    fill_en = 1; fill_asid = asid; fill_global = g; fill_level = 2'(lvl);
    fill_vaddr = va; fill_paddr = pa; fill_pte = pte; fill_pte_addr = pta;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic flush(input logic ua, input logic [15:0] asid, input logic uv,
                       input logic [38:0] va);
    flush_en = 1; flush_use_asid = ua; flush_asid = asid;
    flush_use_addr = uv; flush_vaddr = va;
    @(negedge clk);
    flush_en = 0;
  endtask

  task automatic update(input logic [63:0] pte);
    upd_en = 1; upd_pte = pte;
    @(negedge clk);
    upd_en = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [38:0] va1, va2, va3;
    logic [55:0] pa1, pa2, pa3, pt1;
    logic [63:0] pte1, pte2;
    va1 = 39'h12_3456_7ABC; pa1 = 56'h00_00AB_CDEF_0ABC; pte1 = 64'h0000_0000_2AF3_C0CF;
    pt1 = 56'h00_0000_8000_1018;
    va2 = 39'h40_0020_0000; pa2 = 56'h00_0001_4060_0000;
    va3 = 39'h40_4000_0000; pa3 = 56'h00_0012_3456_789A;
    pte2 = 64'h0000_0000_0000_00FF;

    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state at the ports
    n_checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_paddr !== 0 || rsp_pte !== 0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: actual v=%0b h=%0b pa=%h expected 0 0 0",
               rsp_valid, rsp_hit, rsp_paddr);
    end
    lookup(16'd5, va1, 0, 0, 0, 0, "R1 lookup after reset");

    // R2 R3 R4 level 0
    fill(16'd5, 0, 0, va1, pa1, pte1, pt1);
    lookup(16'd5, 39'h12_3456_7123, 1, xlate(pa1, 39'h12_3456_7123, 0), pte1, pt1, "R4 hit offset merge");
    lookup(16'd6, va1, 0, 0, 0, 0, "R2 asid mismatch miss");
    lookup(16'd5, va1 + 39'h1000, 0, 0, 0, 0, "R3 next 4K page miss");

    // R3 level 1
    fill(16'd5, 0, 1, va2, pa2, pte1, pt1);
    lookup(16'd5, va2 | 39'h1F_F123, 1, xlate(pa2, va2 | 39'h1F_F123, 1), pte1, pt1, "R3 2M page hit");
    lookup(16'd5, va2 ^ (39'd1 << 21), 0, 0, 0, 0, "R3 2M boundary miss");

    // R4 level 2, low physical bits cleared at fill
    fill(16'd5, 0, 2, va3, pa3, pte1, pt1);
    lookup(16'd5, va3 | 39'h2345_6789, 1, xlate(pa3, va3 | 39'h2345_6789, 2), pte1, pt1, "R4 1G page masked fill");
    lookup(16'd5, va3 ^ (39'd1 << 30), 0, 0, 0, 0, "R3 1G boundary miss");

    // R2 R9 global entry
    fill(16'd3, 1, 0, va1, pa1, pte1, pt1);
    lookup(16'd9, va1, 1, xlate(pa1, va1, 0), pte1, pt1, "R2 global any asid");
    flush(1, 16'd3, 0, 0);
    lookup(16'd3, va1, 1, xlate(pa1, va1, 0), pte1, pt1, "R9 global kept by asid flush");

    // R9 non-global
    fill(16'd7, 0, 0, va1, pa1, pte1, pt1);
    flush(1, 16'd8, 0, 0);
    lookup(16'd7, va1, 1, xlate(pa1, va1, 0), pte1, pt1, "R9 other asid kept");
    flush(1, 16'd7, 0, 0);
    lookup(16'd7, va1, 0, 0, 0, 0, "R9 equal asid cleared");

    // R7 update
    fill(16'd7, 0, 0, va1, pa1, pte1, pt1);
    update(pte2);
    lookup(16'd7, va1, 1, xlate(pa1, va1, 0), pte2, pt1, "R7 updated pte");
    flush(0, 0, 0, 0);
    update(pte1);
    lookup(16'd7, va1, 0, 0, 0, 0, "R7 update on empty ignored");

    // R10 address only
    fill(16'd4, 1, 1, va2, pa2, pte1, pt1);
    flush(0, 0, 1, va2 ^ (39'd1 << 21));
    lookup(16'd4, va2, 1, xlate(pa2, va2, 1), pte1, pt1, "R10 other page kept");
    flush(0, 0, 1, va2 | 39'h1_2345);
    lookup(16'd4, va2, 0, 0, 0, 0, "R10 same page cleared");

    // R11 both filters
    fill(16'd4, 0, 0, va1, pa1, pte1, pt1);
    flush(1, 16'd2, 1, va1);
    lookup(16'd4, va1, 1, xlate(pa1, va1, 0), pte1, pt1, "R11 asid differs kept");
    flush(1, 16'd4, 1, va1 + 39'h1000);
    lookup(16'd4, va1, 1, xlate(pa1, va1, 0), pte1, pt1, "R11 page differs kept");
    flush(1, 16'd4, 1, va1);
    lookup(16'd4, va1, 0, 0, 0, 0, "R11 both match cleared");

    // R8 unfiltered flush on global
    fill(16'd4, 1, 0, va1, pa1, pte1, pt1);
    flush(0, 0, 0, 0);
    lookup(16'd4, va1, 0, 0, 0, 0, "R8 flush all cleared global");

    // R6 fill beats same-cycle flush, and replaces the old entry
    flush_en = 1; flush_use_asid = 0; flush_use_addr = 0;
    fill(16'd1, 0, 0, va1, pa1, pte1, pt1);
    flush_en = 0;
    lookup(16'd1, va1, 1, xlate(pa1, va1, 0), pte1, pt1, "R6 fill over flush");
    fill(16'd1, 0, 1, va2, pa2, pte2, pt1);
    lookup(16'd1, va1, 0, 0, 0, 0, "R6 old entry replaced");
    lookup(16'd1, va2, 1, xlate(pa2, va2, 1), pte2, pt1, "R6 new entry hit");

    // R5 same-cycle lookup sees state before the flush
    flush_en = 1;
    lookup(16'd1, va2, 1, xlate(pa2, va2, 1), pte2, pt1, "R5 lookup before flush");
    flush_en = 0;
    lookup(16'd1, va2, 0, 0, 0, 0, "R5 flush then miss");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R5 missing responses: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule